// File: doc/BRIEF.md
# Lane bit-plane packer

This block turns one 24-bit colour pixel for one output lane into 24 single-bit updates of a shared bit-plane memory. Each word of that memory carries one bit slot for up to 32 lanes at once. Bit k of a word belongs to lane k. Because each update is a read-modify-write that changes only the selected lane's bit, several independent LED strings can be packed into the same words one pixel at a time, in any order. A later stage reads the words in address order and drives all lanes in parallel.

A pixel comes in on a valid/ready stream together with its pixel index and lane number. The packer reads each of the pixel's 24 words, changes the lane's bit, and writes the word back. Reads and writes run in a two-stage pipeline over a simple dual-port memory that has a one-cycle read latency. A plain blank request clears the whole data region to zero. A pixel index outside the configured region is consumed and rejected with a one-cycle error pulse, and no memory access is made.

Back-pressure works as follows. A pixel transfers on a rising edge where both `pix_valid` and `pix_ready` are high. `pix_ready` stays low while an update or a blank is in progress. It is also low in any cycle where `blank_req` is high, so a blank always takes precedence over a waiting pixel. While `pix_ready` is low, the source must hold its pixel, index and lane stable.

Top module: `bitplane_packer`

## Requirements
- R1: The lane number L (0 to 31) selects bit L of each memory word; no other bit position is ever used for that lane.
- R2: The pixel is given as {green[7:0], red[7:0], blue[7:0]} in bits 23:0. Word slot s (0 to 23) of a pixel carries pixel bit 23-s. Green therefore fills slots 0 to 7, red fills slots 8 to 15 and blue fills slots 16 to 23, and each colour is sent most significant bit first.
- R3: The words of pixel n are at addresses n*24 to n*24+23.
- R4: A 1 in a pixel bit sets the lane's bit in its word, and a 0 clears it.
- R5: Every bit of a touched word outside the selected lane keeps the value it held before the update.
- R6: An accepted pixel holds `pix_ready` low for exactly 25 cycles, counted from the cycle after the accepting edge.
- R7: A pixel whose index is MAX_PIXELS or above is consumed. `err_pulse` goes high for exactly the one cycle after the accepting edge, no memory read or write is made, and `pix_ready` stays high.
- R8: A `blank_req` seen while idle writes zero to all MAX_PIXELS*24 words in increasing address order, one word per cycle, with `pix_ready` low during those cycles. `pix_ready` is also low in every cycle where `blank_req` is high.
- R9: During reset and straight after it, `pix_ready` is high and `err_pulse`, `mem_rd_en` and `mem_wr_en` are low.
- R10: The 24 reads of a pixel fall in 24 consecutive cycles, starting the cycle after acceptance. The write of each slot follows its read one cycle later, at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Packer can take a pixel this cycle |
| pix_data | input | 24 | Colour, {green, red, blue} |
| pix_index | input | IDX_W (8) | Pixel position in the string |
| pix_lane | input | LANE_W (5) | Lane (string) number |
| blank_req | input | 1 | Request to clear the whole region |
| err_pulse | output | 1 | One-cycle flag for an out-of-range index |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W (9) | Memory read address |
| mem_rd_data | input | LANES (32) | Read word, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W (9) | Memory write address |
| mem_wr_data | output | LANES (32) | Word to be written |

## Verification
Counting from the accepting edge, the first read strobe appears in the cycle right after it. The write for that slot comes one cycle later. The last write falls in the 25th cycle, and ready returns in the 26th. A rejected index shows its error pulse only in that first cycle. A blank keeps ready low for exactly 384 cycles at the default size. The bench drives inputs and samples outputs on falling edges and walks forward one falling edge at a time from the accepting edge. It counts the busy, read and write cycles in that window and notes the cycles of the first read and the first write. Only after ready has returned does it compare the whole memory image against a model built from the requirements.

// File: rtl/bpk_pkg.sv
package bpk_pkg;
  localparam int SLOTS_PER_PIXEL = 24;
  localparam int COLOUR_BITS     = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_BLANK = 2'd2
  } bpk_state_e;
endpackage

// File: rtl/bpk_lane_decode.sv
module bpk_lane_decode #(
  parameter int LANES  = 32,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [LANE_W-1:0] lane,
  output logic [LANES-1:0]  mask
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g] = (lane == LANE_W'(g));
  end
endmodule

// File: rtl/bpk_bit_pick.sv
module bpk_bit_pick
  import bpk_pkg::*;
#(
  parameter int SLOT_W = $clog2(SLOTS_PER_PIXEL)
) (
  input  logic [SLOTS_PER_PIXEL-1:0] pixel,
  input  logic [SLOT_W-1:0]          slot,
  output logic                       bit_out
);
  // Slot 0 carries the top bit (green MSB); the last slot carries blue LSB.
  logic [SLOTS_PER_PIXEL-1:0] taps;

  for (genvar s = 0; s < SLOTS_PER_PIXEL; s++) begin : g_tap
    assign taps[s] = pixel[SLOTS_PER_PIXEL-1-s];
  end

  always_comb begin
    bit_out = 1'b0;
    for (int s = 0; s < SLOTS_PER_PIXEL; s++) begin
      if (slot == SLOT_W'(s)) bit_out = taps[s];
    end
  end
endmodule

// File: rtl/bpk_merge.sv
module bpk_merge #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] old_word,
  input  logic [LANES-1:0] lane_mask,
  input  logic             bit_val,
  output logic [LANES-1:0] new_word
);
  always_comb begin
    if (bit_val) new_word = old_word | lane_mask;
    else         new_word = old_word & ~lane_mask;
  end
endmodule

// File: rtl/bpk_seq.sv
module bpk_seq
  import bpk_pkg::*;
#(
  parameter int MAX_PIXELS = 16,
  parameter int IDX_W      = 8,
  parameter int ADDR_W     = 9,
  parameter int SLOT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_index,
  input  logic              blank_req,
  output logic              pix_ready,
  output logic              load_en,
  output logic              err_pulse,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              wr_pend,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              blank_on,
  output logic [ADDR_W-1:0] blank_addr
);
  localparam int TOTAL_WORDS = MAX_PIXELS * SLOTS_PER_PIXEL;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS_PER_PIXEL - 1);
  localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(TOTAL_WORDS - 1);

  bpk_state_e state_q;
  logic idle, handshake, index_ok, start_blank;
  logic [ADDR_W-1:0] base_addr;

  assign idle        = (state_q == ST_IDLE) && !wr_pend;
  assign pix_ready   = idle && !blank_req;
  assign handshake   = pix_valid && pix_ready;
  assign index_ok    = (pix_index < IDX_W'(MAX_PIXELS));
  assign load_en     = handshake && index_ok;
  assign start_blank = idle && blank_req;
  assign base_addr   = ADDR_W'(pix_index) * ADDR_W'(SLOTS_PER_PIXEL);
  assign rd_en       = (state_q == ST_RUN);
  assign blank_on    = (state_q == ST_BLANK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rd_addr    <= '0;
      rd_slot    <= '0;
      blank_addr <= '0;
      err_pulse  <= 1'b0;
      wr_pend    <= 1'b0;
      wr_addr    <= '0;
      wr_slot    <= '0;
    end else begin
      err_pulse <= handshake && !index_ok;
      wr_pend   <= rd_en;
      wr_addr   <= rd_addr;
      wr_slot   <= rd_slot;
      case (state_q)
        ST_IDLE: begin
          if (start_blank) begin
            state_q    <= ST_BLANK;
            blank_addr <= '0;
          end else if (load_en) begin
            state_q <= ST_RUN;
            rd_addr <= base_addr;
            rd_slot <= '0;
          end
        end
        ST_RUN: begin
          rd_addr <= rd_addr + ADDR_W'(1);
          rd_slot <= rd_slot + SLOT_W'(1);
          if (rd_slot == LAST_SLOT) state_q <= ST_IDLE;
        end
        ST_BLANK: begin
          blank_addr <= blank_addr + ADDR_W'(1);
          if (blank_addr == LAST_WORD) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitplane_packer.sv
module bitplane_packer
  import bpk_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int MAX_PIXELS = 16,
  parameter int IDX_W      = 8,
  parameter int LANE_W     = $clog2(LANES),
  parameter int ADDR_W     = $clog2(MAX_PIXELS * SLOTS_PER_PIXEL)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pix_valid,
  output logic                       pix_ready,
  input  logic [SLOTS_PER_PIXEL-1:0] pix_data,
  input  logic [IDX_W-1:0]           pix_index,
  input  logic [LANE_W-1:0]          pix_lane,
  input  logic                       blank_req,
  output logic                       err_pulse,
  output logic                       mem_rd_en,
  output logic [ADDR_W-1:0]          mem_rd_addr,
  input  logic [LANES-1:0]           mem_rd_data,
  output logic                       mem_wr_en,
  output logic [ADDR_W-1:0]          mem_wr_addr,
  output logic [LANES-1:0]           mem_wr_data
);
  localparam int SLOT_W = $clog2(SLOTS_PER_PIXEL);

  logic                       load_en, wr_pend, blank_on, cur_bit;
  logic [SLOT_W-1:0]          rd_slot, wr_slot;
  logic [ADDR_W-1:0]          wr_addr, blank_addr;
  logic [LANES-1:0]           mask_d, mask_q, merged;
  logic [SLOTS_PER_PIXEL-1:0] pixel_q;

  bpk_seq #(
    .MAX_PIXELS(MAX_PIXELS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_index(pix_index),
    .blank_req(blank_req), .pix_ready(pix_ready), .load_en(load_en),
    .err_pulse(err_pulse), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
    .rd_slot(rd_slot), .wr_pend(wr_pend), .wr_addr(wr_addr),
    .wr_slot(wr_slot), .blank_on(blank_on), .blank_addr(blank_addr)
  );

  bpk_lane_decode #(.LANES(LANES), .LANE_W(LANE_W)) u_dec (
    .lane(pix_lane), .mask(mask_d)
  );

  // Pixel and lane mask are captured once per accepted pixel.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pixel_q <= '0;
      mask_q  <= '0;
    end else if (load_en) begin
      pixel_q <= pix_data;
      mask_q  <= mask_d;
    end
  end

  bpk_bit_pick #(.SLOT_W(SLOT_W)) u_pick (
    .pixel(pixel_q), .slot(wr_slot), .bit_out(cur_bit)
  );

  bpk_merge #(.LANES(LANES)) u_merge (
    .old_word(mem_rd_data), .lane_mask(mask_q), .bit_val(cur_bit), .new_word(merged)
  );

  // rd_slot is the read-stage slot; it reaches the write stage as wr_slot.
  logic unused_slot;
  assign unused_slot = ^rd_slot;

  assign mem_wr_en   = wr_pend | blank_on;
  assign mem_wr_addr = blank_on ? blank_addr : wr_addr;
  assign mem_wr_data = blank_on ? '0 : merged;
endmodule

// File: rtl/bpk_checker.sv
module bpk_checker #(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 9,
  parameter int TOTAL_WORDS = 384
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_ready,
  input logic              err_pulse,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic [LANES-1:0]  mem_rd_data,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [LANES-1:0]  mem_wr_data
);
  // R5 / R1: a read-modify-write changes at most one bit of the word
  a_r5_single_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_rd_en)) |-> ($countones(mem_wr_data ^ mem_rd_data) <= 1));

  // R10: every read is followed by a write to the same address
  a_r10_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (mem_wr_en && mem_wr_addr == $past(mem_rd_addr)));

  // R6: no pixel is taken while its reads are running
  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !pix_ready);

  // R7: error lasts one cycle and comes with no memory access
  a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
  a_r7_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (!mem_rd_en && !mem_wr_en));

  // R8: writes not preceded by a read are blank writes of zero, in increasing order
  a_r8_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !$past(mem_rd_en)) |-> (mem_wr_data == '0));

  // R3: reads stay inside the data region
  a_r3_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr < ADDR_W'(TOTAL_WORDS)));

  // R10: a write never hits the word being read in the same cycle
  a_r10_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_wr_en) |-> (mem_rd_addr != mem_wr_addr));
endmodule

bind bitplane_packer bpk_checker #(
  .LANES(LANES), .ADDR_W(ADDR_W), .TOTAL_WORDS(MAX_PIXELS * bpk_pkg::SLOTS_PER_PIXEL)
) u_bpk_checker (
  .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .err_pulse(err_pulse),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
  .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
);

// File: tb/test_bitplane_packer.sv
`timescale 1ns/1ps
module test_bitplane_packer;
  localparam int LANES  = 32;
  localparam int MAXP   = 16;
  localparam int IDX_W  = 8;
  localparam int LANE_W = 5;
  localparam int ADDR_W = 9;
  localparam int TOTAL  = MAXP * 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0, blank_req = 1'b0;
  logic [23:0] pix_data = '0;
  logic [IDX_W-1:0] pix_index = '0;
  logic [LANE_W-1:0] pix_lane = '0;
  logic pix_ready, err_pulse, mem_rd_en, mem_wr_en;
  logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
  logic [LANES-1:0] mem_rd_data, mem_wr_data;

  int n_tests = 0, n_fail = 0;
  logic [LANES-1:0] mem [TOTAL];
  logic [LANES-1:0] ref_mem [TOTAL];

  always #2.5 clk = ~clk;

  bitplane_packer #(.LANES(LANES), .MAX_PIXELS(MAXP), .IDX_W(IDX_W)) i_bitplane_packer (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_index(pix_index), .pix_lane(pix_lane),
    .blank_req(blank_req), .err_pulse(err_pulse),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  // Memory model: one-cycle read latency, read returns the old word.
  always @(posedge clk) begin
    if (mem_wr_en && int'(mem_wr_addr) < TOTAL) mem[mem_wr_addr] <= mem_wr_data;
    if (mem_rd_en && int'(mem_rd_addr) < TOTAL) mem_rd_data <= mem[mem_rd_addr];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference update built from R1-style lane bit, slot order and set/clear rules.
  function automatic void ref_apply(input int lane, input int idx, input logic [23:0] d);
    for (int s = 0; s < 24; s++) begin
      if (d[23-s]) ref_mem[idx*24+s][lane] = 1'b1;
      else         ref_mem[idx*24+s][lane] = 1'b0;
    end
  endfunction

  task automatic compare_mem(input string req);
    int bad = 0; int first = -1;
    for (int a = 0; a < TOTAL; a++) begin
      if (mem[a] !== ref_mem[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    if (first < 0) check(1'b1, req, "memory image", 0, 0);
    else check(1'b0, req, $sformatf("memory word %0d (%0d bad)", first, bad),
               longint'(mem[first]), longint'(ref_mem[first]));
  endtask

  task automatic do_blank();
    int busy = 0; int wrs = 0;
    @(negedge clk);
    blank_req = 1'b1;
    #0.1;
    check(pix_ready == 1'b0, "R8", "ready low while blank_req high", pix_ready, 0);
    @(negedge clk);
    blank_req = 1'b0;
    while (!pix_ready && busy < 1000) begin
      if (mem_wr_en) wrs++;
      busy++;
      @(negedge clk);
    end
    check(busy == TOTAL, "R8", "blank busy cycles", busy, TOTAL);
    check(wrs == TOTAL, "R8", "blank write cycles", wrs, TOTAL);
    for (int a = 0; a < TOTAL; a++) ref_mem[a] = '0;
    compare_mem("R8");
  endtask

  task automatic send_pixel(input int lane, input int idx, input logic [23:0] d);
    int busy = 0; int rds = 0; int wrs = 0; int frd = -1; int fwr = -1;
    @(negedge clk);
    pix_valid = 1'b1; pix_lane = LANE_W'(lane); pix_index = IDX_W'(idx); pix_data = d;
    while (!pix_ready) @(negedge clk);
    @(negedge clk);
    pix_valid = 1'b0;
    if (idx >= MAXP) begin
      check(err_pulse == 1'b1, "R7", "error pulse after accept", err_pulse, 1);
      check(pix_ready == 1'b1 && !mem_rd_en && !mem_wr_en, "R7", "ready high, no access",
            {pix_ready, mem_rd_en, mem_wr_en}, 3'b100);
      @(negedge clk);
      check(err_pulse == 1'b0, "R7", "error pulse length", err_pulse, 0);
      compare_mem("R7");
    end else begin
      while (!pix_ready && busy < 100) begin
        if (mem_rd_en) begin rds++; if (frd < 0) frd = busy; end
        if (mem_wr_en) begin wrs++; if (fwr < 0) fwr = busy; end
        busy++;
        @(negedge clk);
      end
      check(busy == 25, "R6", "busy cycles", busy, 25);
      check(rds == 24 && wrs == 24 && frd == 0 && fwr == 1, "R10", "read/write cadence",
            (rds << 16) | (wrs << 8) | (fwr << 4) | frd, (24 << 16) | (24 << 8) | (1 << 4));
      ref_apply(lane, idx, d);
      compare_mem("R1 R2 R3 R4 R5");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2468));
    for (int a = 0; a < TOTAL; a++) mem[a] = $urandom;
    repeat (3) @(negedge clk);
    check(pix_ready && !err_pulse && !mem_rd_en && !mem_wr_en, "R9", "outputs in reset",
          {pix_ready, err_pulse, mem_rd_en, mem_wr_en}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(pix_ready && !err_pulse && !mem_rd_en && !mem_wr_en, "R9", "outputs after reset",
          {pix_ready, err_pulse, mem_rd_en, mem_wr_en}, 4'b1000);

    do_blank();
    // Directed corners: lowest lane/index, highest lane/index, set then clear.
    send_pixel(0, 0, 24'hFFFFFF);
    send_pixel(31, MAXP-1, 24'hA53C0F);
    send_pixel(5, 3, 24'hFFFFFF);
    send_pixel(6, 3, 24'h800001);
    send_pixel(5, 3, 24'h000000);
    send_pixel(0, 0, 24'h0F0F0F);
    // R7: out-of-range index, boundary value and far above.
    send_pixel(7, MAXP, 24'hFFFFFF);
    send_pixel(9, 200, 24'h123456);
    // Constrained random: any lane, legal index, any colour.
    for (int k = 0; k < 60; k++) begin
      send_pixel(int'($urandom_range(31, 0)), int'($urandom_range(MAXP-1, 0)), 24'($urandom));
    end
    send_pixel(12, MAXP + 1, 24'h00FF00);
    do_blank();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule